// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Byte Engine

This block is the byte-level slave side of a two-wire serial memory of 1 KiB. A bus front end, which is a separate block, filters the lines and turns them into single-cycle events: a start, a stop, and a strobe for each sampled data bit. The engine takes a control byte and a word address, and it acknowledges each byte it accepts. It hands write data bytes to an external page buffer. For reads, it shifts bytes out of an internal synchronous register array. The array is split into four blocks of 256 bytes, and the control byte selects the block.

The engine has one output towards the bus, `sda_low`. When it is high, the front end pulls the data line low. This output is a register and changes only in the clock after a strobe, start or stop, so it holds one value for the whole bit slot that follows. A slot counts as one of nine per byte: eight data slots and then the acknowledge slot. While the external write cycle reports `busy`, the engine refuses to acknowledge any byte.

The array is loaded through a commit port driven by the page buffer. Strobes must be at least three clocks apart.

Top module: `serial_mem_slave`

## Requirements
- R1: A control byte is received MSB first. It is accepted when bits 7..4 equal 1010 and `busy` is low. Bits 2..1 select the block and bit 0 selects the direction (1 = read). An accepted byte gets `sda_low`=1 for the whole ninth slot.
- R2: A control byte whose bits 7..4 differ from 1010 gets no acknowledge. Every later slot stays released, and no `wr_valid` occurs, until the next start.
- R3: After a write control byte, the word-address byte and every data byte are acknowledged. Data byte n raises `wr_valid` for one cycle, with `wr_addr` = {block, word} + n and `wr_data` = the byte.
- R4: If `busy` is high when the eighth bit of any received byte is strobed, the byte gets no acknowledge and no `wr_valid`. The slave then stays released until the next start.
- R5: A read control byte sent after a repeated start that follows the word address starts the output at address {block, word}. Each data bit is driven MSB first during its slot as `sda_low` = inverted bit.
- R6: When the master acknowledges a read byte (data line low in its ninth slot), the next byte comes from the following address, with 1023 wrapping to 0.
- R7: When the master does not acknowledge a read byte, the slave releases the line and drives nothing until the next start.
- R8: A start or a stop releases `sda_low` on the next clock. A stop returns the engine to idle.
- R9: During and after reset, `sda_low` and `wr_valid` are 0.
- R10: `sda_low` changes only in the clock after a strobe, start or stop, and holds between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_evt | input | 1 | Start or repeated start seen on the bus, one cycle |
| stop_evt | input | 1 | Stop seen on the bus, one cycle |
| bit_strobe | input | 1 | One sampled bit is ready on `bit_in` |
| bit_in | input | 1 | Sampled data line value |
| busy | input | 1 | Self-timed write cycle in progress |
| sda_low | output | 1 | Pull the data line low in the current slot |
| wr_valid | output | 1 | One received write byte for the page buffer |
| wr_addr | output | ADDR_W | Address of that byte |
| wr_data | output | 8 | Value of that byte |
| prog_we | input | 1 | Commit write into the array |
| prog_addr | input | ADDR_W | Commit address |
| prog_data | input | 8 | Commit data |

## Verification
The array is filled with values that are distinct across blocks, so a read that ignored the block bits would return data from the wrong block. Writes are tried at an unaligned address inside block 1. Reads are tried in three ways: a random read spanning a block boundary, a read wrapping from the last address to the first, and a read cut short by a repeated start while the slave holds the line low. Each way separates a different address path. A wrong prefix, `busy` at the control byte, and `busy` raised in the middle of a write each show whether the slave drops the transfer at the first refused byte or resumes later. Two further cases show whether release follows the event or the byte boundary: a stop during an acknowledge, and a byte sent after a master not-acknowledge.

// File: rtl/serial_mem_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the serial memory slave.
package serial_mem_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_DROP
    } state_t;
endpackage

// File: rtl/sms_slot_ctr.sv
`timescale 1ns/1ps
// Bit-slot counter: counts strobes within a byte frame of SLOTS slots
// (data bits then acknowledge). Assumes clear and advance are single-cycle pulses.
module sms_slot_ctr #(
    parameter int SLOTS = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic last_data,
    output logic ack_slot
);
    localparam int CW = $clog2(SLOTS);
    logic [CW-1:0] cnt;

    // Advance the slot index, wrapping after the acknowledge slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (advance)
            cnt <= (cnt == CW'(SLOTS - 1)) ? '0 : cnt + 1'b1;
    end

    assign last_data = (cnt == CW'(SLOTS - 2));
    assign ack_slot  = (cnt == CW'(SLOTS - 1));
endmodule

// File: rtl/sms_rx_shift.sv
`timescale 1ns/1ps
// Receive shifter: collects bits MSB first. byte_next is the byte that
// includes the bit presented in the current strobe cycle.
module sms_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] byte_next
);
    logic [W-1:0] q;

    // Shift one bit in on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (shift_en)
            q <= byte_next;
    end

    assign byte_next = {q[W-2:0], bit_in};
endmodule

// File: rtl/sms_mem.sv
`timescale 1ns/1ps
// Synchronous register array: one write port, one registered read port.
// The array itself is not reset; contents are defined by commit writes.
module sms_mem #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    // Commit writes from the page buffer.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Register the read word every cycle.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/serial_mem_slave.sv
`timescale 1ns/1ps
// Byte engine of a two-wire serial memory slave. Decodes the control byte,
// the word address, write data and read data, and drives the acknowledge.
// Assumes the front end delivers start/stop/strobe as single-cycle pulses,
// with strobes at least three clocks apart, and ADDR_W between 9 and 11.
module serial_mem_slave
    import serial_mem_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              bit_strobe,
    input  logic              bit_in,
    input  logic              busy,
    output logic              sda_low,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [BYTE_W-1:0] prog_data
);
    localparam int BLK_W = ADDR_W - BYTE_W;

    state_t              state;
    logic [ADDR_W-1:0]   ptr;
    logic                rw;
    logic [BYTE_W-1:0]   rbyte;
    logic [BYTE_W-1:0]   rdata;
    logic [BYTE_W-1:0]   byte_next;
    logic                last_data;
    logic                ack_slot;
    logic                rx_state;
    logic                rx_last;
    logic                bad_prefix;
    logic                in_ctrl;

    sms_slot_ctr #(.SLOTS(BYTE_W + 1)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_evt),
        .advance   (bit_strobe),
        .last_data (last_data),
        .ack_slot  (ack_slot)
    );

    sms_rx_shift #(.W(BYTE_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (bit_strobe),
        .bit_in    (bit_in),
        .byte_next (byte_next)
    );

    sms_mem #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
        .clk   (clk),
        .we    (prog_we),
        .waddr (prog_addr),
        .wdata (prog_data),
        .raddr (ptr),
        .rdata (rdata)
    );

    assign in_ctrl    = (state == ST_CTRL);
    assign rx_state   = in_ctrl || (state == ST_ADDR) || (state == ST_WDATA);
    assign rx_last    = bit_strobe && last_data && rx_state;
    assign bad_prefix = (byte_next[BYTE_W-1 -: 4] != DEV_CODE);

    // Transfer sequencing, acknowledge drive, pointer and write hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ptr      <= '0;
            rw       <= 1'b0;
            rbyte    <= '0;
            sda_low  <= 1'b0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (start_evt) begin
                state   <= ST_CTRL;
                sda_low <= 1'b0;
            end else if (stop_evt) begin
                state   <= ST_IDLE;
                sda_low <= 1'b0;
            end else if (bit_strobe) begin
                if (rx_state && last_data) begin
                    if (busy || (in_ctrl && bad_prefix)) begin
                        state   <= ST_DROP;
                        sda_low <= 1'b0;
                    end else begin
                        sda_low <= 1'b1;
                        case (state)
                            ST_CTRL: begin
                                rw <= byte_next[0];
                                ptr[ADDR_W-1:BYTE_W] <= byte_next[BLK_W:1];
                            end
                            ST_ADDR: ptr[BYTE_W-1:0] <= byte_next;
                            default: begin
                                wr_valid <= 1'b1;
                                wr_addr  <= ptr;
                                wr_data  <= byte_next;
                                ptr      <= ptr + 1'b1;
                            end
                        endcase
                    end
                end else if (rx_state && ack_slot) begin
                    case (state)
                        ST_CTRL: begin
                            if (rw) begin
                                state   <= ST_RDATA;
                                rbyte   <= rdata;
                                sda_low <= ~rdata[BYTE_W-1];
                            end else begin
                                state   <= ST_ADDR;
                                sda_low <= 1'b0;
                            end
                        end
                        ST_ADDR: begin
                            state   <= ST_WDATA;
                            sda_low <= 1'b0;
                        end
                        default: sda_low <= 1'b0;
                    endcase
                end else if (state == ST_RDATA) begin
                    if (ack_slot) begin
                        if (!bit_in) begin
                            rbyte   <= rdata;
                            sda_low <= ~rdata[BYTE_W-1];
                        end else begin
                            state   <= ST_DROP;
                            sda_low <= 1'b0;
                        end
                    end else if (last_data) begin
                        sda_low <= 1'b0;
                        ptr     <= ptr + 1'b1;
                    end else begin
                        sda_low <= ~rbyte[BYTE_W-2];
                        rbyte   <= rbyte << 1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sms_checker.sv
`timescale 1ns/1ps
// Protocol checker for serial_mem_slave, attached by bind.
module sms_checker (
    input logic clk,
    input logic rst_n,
    input logic start_evt,
    input logic stop_evt,
    input logic bit_strobe,
    input logic busy,
    input logic sda_low,
    input logic wr_valid,
    input logic rx_last,
    input logic in_ctrl,
    input logic bad_prefix
);
    assert_release_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_low);

    assert_release_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !start_evt) |=> !sda_low);

    assert_nack_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_last && busy && !start_evt && !stop_evt) |=> !sda_low);

    assert_nack_prefix_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_last && in_ctrl && bad_prefix && !start_evt && !stop_evt) |=> !sda_low);

    assert_write_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(!busy));

    assert_write_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    assert_hold_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_strobe && !start_evt && !stop_evt) |=> $stable(sda_low));
endmodule

bind serial_mem_slave sms_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .bit_strobe (bit_strobe),
    .busy       (busy),
    .sda_low    (sda_low),
    .wr_valid   (wr_valid),
    .rx_last    (rx_last),
    .in_ctrl    (in_ctrl),
    .bad_prefix (bad_prefix)
);

// File: tb/serial_mem_slave_tb.sv
`timescale 1ns/1ps
// Self-checking bench: behavioural master plus an expected-line model,
// compared on every clock between bit slots.
module serial_mem_slave_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_evt = 1'b0, stop_evt = 1'b0, bit_strobe = 1'b0, bit_in = 1'b1, busy = 1'b0;
    logic sda_low, wr_valid;
    logic [9:0] wr_addr;
    logic [7:0] wr_data;
    logic prog_we = 1'b0;
    logic [9:0] prog_addr = '0;
    logic [7:0] prog_data = '0;

    int n_cmp = 0;
    int n_bad = 0;
    logic [17:0] wq[$];

    always #2.5 clk = ~clk;

    serial_mem_slave u_dut (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
        .bit_strobe(bit_strobe), .bit_in(bit_in), .busy(busy), .sda_low(sda_low),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data)
    );

    function automatic logic [7:0] mdat(int a);
        return 8'((a * 37 + (a >> 8) * 101 + 11) & 255);
    endfunction

    function automatic void check(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endfunction

    // Write monitor: every write hand-off must match the expected queue.
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            if (wq.size() == 0)
                check(1'b0, "R3/R4 unexpected write", {wr_addr, wr_data}, 0);
            else begin
                logic [17:0] e;
                e = wq.pop_front();
                check({wr_addr, wr_data} === e, "R3", {wr_addr, wr_data}, e);
            end
        end
    end

    task automatic expect_sda(bit e, string req);
        repeat (2) begin
            @(negedge clk);
            check(sda_low === e, req, sda_low, e);
        end
    endtask

    task automatic slot(bit mb, bit e_cur, string req);
        expect_sda(e_cur, req);
        bit_in = mb & ~sda_low;
        bit_strobe = 1'b1;
        @(negedge clk);
        bit_strobe = 1'b0;
    endtask

    task automatic bus_start();
        @(negedge clk) start_evt = 1'b1;
        @(negedge clk) start_evt = 1'b0;
    endtask

    task automatic bus_stop();
        @(negedge clk) stop_evt = 1'b1;
        @(negedge clk) stop_evt = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] b, bit ack, string req);
        for (int i = 7; i >= 0; i--) slot(b[i], 1'b0, req);
        slot(1'b1, ack, req);
    endtask

    task automatic read_byte(logic [7:0] b, bit mack, string req);
        for (int i = 7; i >= 0; i--) slot(1'b1, ~b[i], req);
        slot(~mack, 1'b0, req);
    endtask

    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(sda_low === 1'b0, "R9 reset sda", sda_low, 0);
        check(wr_valid === 1'b0, "R9 reset wr", wr_valid, 0);
        rst_n = 1'b1;
        for (int a = 0; a < 1024; a++) begin
            @(negedge clk);
            prog_we = 1'b1; prog_addr = 10'(a); prog_data = mdat(a);
        end
        @(negedge clk) prog_we = 1'b0;

        // R1/R3: write three bytes into block 1 at word 0x3C
        wq.push_back({10'h13C, 8'h11});
        wq.push_back({10'h13D, 8'h22});
        wq.push_back({10'h13E, 8'h33});
        bus_start();
        send_byte(8'hA2, 1'b1, "R1");
        send_byte(8'h3C, 1'b1, "R3");
        send_byte(8'h11, 1'b1, "R3");
        send_byte(8'h22, 1'b1, "R3");
        send_byte(8'h33, 1'b1, "R3");
        bus_stop();
        expect_sda(1'b0, "R8");

        // R5/R6/R7: random read in block 2 across the block boundary
        bus_start();
        send_byte(8'hA4, 1'b1, "R1");
        send_byte(8'hFE, 1'b1, "R3");
        bus_start();
        send_byte(8'hA5, 1'b1, "R1");
        read_byte(mdat(10'h2FE), 1'b1, "R5");
        read_byte(mdat(10'h2FF), 1'b1, "R6");
        read_byte(mdat(10'h300), 1'b0, "R6");
        send_byte(8'h00, 1'b0, "R7");
        bus_stop();

        // R6: wrap from the last address to the first
        bus_start();
        send_byte(8'hA6, 1'b1, "R1");
        send_byte(8'hFF, 1'b1, "R3");
        bus_start();
        send_byte(8'hA7, 1'b1, "R1");
        read_byte(mdat(10'h3FF), 1'b1, "R6");
        read_byte(mdat(10'h000), 1'b0, "R6");
        bus_stop();

        // R8: repeated start while the slave drives a data bit low
        bus_start();
        send_byte(8'hA0, 1'b1, "R1");
        send_byte(8'h10, 1'b1, "R3");
        bus_start();
        send_byte(8'hA1, 1'b1, "R1");
        expect_sda(~mdat(10'h010) >> 7, "R5");
        bus_start();
        expect_sda(1'b0, "R8");
        send_byte(8'hA1, 1'b1, "R1");
        read_byte(mdat(10'h010), 1'b0, "R5");
        bus_stop();

        // R2: wrong prefix then more bytes
        bus_start();
        send_byte(8'hB0, 1'b0, "R2");
        send_byte(8'hA0, 1'b0, "R2");
        bus_stop();

        // R4: busy at the control byte
        busy = 1'b1;
        bus_start();
        send_byte(8'hA0, 1'b0, "R4");
        send_byte(8'h12, 1'b0, "R4");
        bus_stop();
        busy = 1'b0;

        // R4: busy raised in the middle of a write
        bus_start();
        send_byte(8'hA2, 1'b1, "R1");
        send_byte(8'h40, 1'b1, "R3");
        busy = 1'b1;
        send_byte(8'h99, 1'b0, "R4");
        busy = 1'b0;
        send_byte(8'h77, 1'b0, "R4");
        bus_stop();

        // R8: stop during an acknowledge slot
        bus_start();
        for (int i = 7; i >= 0; i--) slot(1'(8'hA0 >> i), 1'b0, "R1");
        expect_sda(1'b1, "R1");
        bus_stop();
        expect_sda(1'b0, "R8");

        repeat (4) @(negedge clk);
        check(wq.size() == 0, "R3 missing writes", wq.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule